// File: doc/BRIEF.md
# Segmented Thermometer-Binary Code Decoder

This block turns a parallel binary code into the switch-control word of a segmented current-steering converter. The code is split in two. The upper field drives a bank of identical unit elements through a thermometer vector. The lower field drives binary-weighted elements directly, with no decoding. The sum of all binary weights is one less than the weight of one unit element, so the full-scale range has no gap or overlap where the two segments meet.

Loading uses two register stages. A holding register captures a new code whenever the valid strobe is high. The code already in the output register keeps driving the switches while the new one waits. On the next edge the held code is decoded and moved into a common retiming register. Every unit-element enable and every binary enable therefore changes on the same clock edge.

With the default settings the code is 14 bits wide: a 6-bit thermometer field that drives 63 unit lines, and an 8-bit binary field. The thermometer field width can be set from 4 to 6 bits. The binary width is whatever is left of the total.

Top module: `seg_code_decoder`

## Requirements
- R1: A synchronous active-high reset clears both register stages and cancels any pending transfer. All thermometer and binary enables read zero on the edge after reset is sampled, and they stay zero until a new code is loaded.
- R2: The number of asserted thermometer lines equals the unsigned value of the upper field, code bits [TOTAL_W-1:BIN_W].
- R3: Thermometer line i (bit i of `therm_en`, counted from bit 0) is asserted exactly when the upper field is greater than i. The asserted lines therefore always form one contiguous run that starts at bit 0.
- R4: `bin_en` bit j equals code bit j for j from 0 to BIN_W-1.
- R5: A code presented while `code_valid` is low is ignored. Without a valid strobe the outputs stay at their current value.
- R6: A code sampled with `code_valid` high on clock edge k appears on both `therm_en` and `bin_en` after edge k+1. Both segments change on that same edge.
- R7: Until its transfer edge, a newly loaded code does not disturb the outputs. The previously transferred code keeps driving them, including when valid codes arrive on consecutive cycles.
- R8: When the upper field rises by one, exactly one more thermometer line turns on, and every line that was already on stays on.
- R9: Code zero gives all enables low. The all-ones code gives every one of the 2^THERM_W-1 unit lines high and every binary enable high.
- R10: The output weight, (number of asserted unit lines) × 2^BIN_W + (value of `bin_en`), equals the code that was transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | Strobe that loads `code_in` into the holding register |
| code_in | input | TOTAL_W | Binary input code |
| therm_en | output | 2^THERM_W-1 | Unit-element enables, thermometer coded |
| bin_en | output | TOTAL_W-THERM_W | Binary-weighted enables |

## Verification
The bench walks the upper field through every value in single steps. A decoder with an off-by-one compare or a reversed line order breaks the single-new-line rule, the contiguity rule or the count rule at some step. Back-to-back strobes and codes presented with the strobe low target the double buffering. A design that bypasses the holding stage shows the new code one cycle early, and one that ignores the strobe lets a stray code reach the switches. A reset that arrives while a transfer is pending must not let the held code through afterwards. The two extreme codes confirm that the binary field tops out one step below a unit element.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

    // Default split of the input word
    localparam int DEF_TOTAL_W = 14;
    localparam int DEF_THERM_W = 6;

    // Allowed range for the unary field width
    localparam int MIN_THERM_W = 4;
    localparam int MAX_THERM_W = 6;

    // State of the holding stage: whether a transfer is owed
    typedef enum logic {
        XFER_IDLE    = 1'b0,
        XFER_PENDING = 1'b1
    } xfer_state_e;

    // Number of unit elements for a unary field of width w
    function automatic int unit_count(input int w);
        return (1 << w) - 1;
    endfunction

    // Weight of one unit element expressed in binary LSBs
    function automatic int unit_weight(input int bin_w);
        return 1 << bin_w;
    endfunction

endpackage

// File: rtl/seg_hold_stage.sv
module seg_hold_stage
    import seg_dec_pkg::*;
#(
    parameter int TOTAL_W = DEF_TOTAL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [TOTAL_W-1:0] code_i,
    output logic [TOTAL_W-1:0] held_code_o,
    output logic               xfer_req_o
);

    logic [TOTAL_W-1:0] held_q;
    xfer_state_e        state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            state_q <= XFER_IDLE;
        end else begin
            if (load_i) begin
                held_q <= code_i;
            end
            state_q <= load_i ? XFER_PENDING : XFER_IDLE;
        end
    end

    assign held_code_o = held_q;
    assign xfer_req_o  = (state_q == XFER_PENDING);

endmodule

// File: rtl/seg_therm_decode.sv
module seg_therm_decode
    import seg_dec_pkg::*;
#(
    parameter int THERM_W = DEF_THERM_W,
    localparam int UNITS  = (1 << THERM_W) - 1
) (
    input  logic [THERM_W-1:0] level_i,
    output logic [UNITS-1:0]   lines_o
);

    // Line n is on when the level exceeds n
    for (genvar n = 0; n < UNITS; n++) begin : g_line
        assign lines_o[n] = (level_i > THERM_W'(n));
    end

endmodule

// File: rtl/seg_retime_stage.sv
module seg_retime_stage #(
    parameter int UNITS = 63,
    parameter int BIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [UNITS-1:0] unary_d,
    input  logic [BIN_W-1:0] binary_d,
    output logic [UNITS-1:0] unary_q,
    output logic [BIN_W-1:0] binary_q
);

    // A single register bank for both segments keeps them edge aligned
    always_ff @(posedge clk) begin
        if (rst) begin
            unary_q  <= '0;
            binary_q <= '0;
        end else if (load_i) begin
            unary_q  <= unary_d;
            binary_q <= binary_d;
        end
    end

endmodule

// File: rtl/seg_code_decoder.sv
module seg_code_decoder
    import seg_dec_pkg::*;
#(
    parameter int TOTAL_W  = DEF_TOTAL_W,
    parameter int THERM_W  = DEF_THERM_W,
    localparam int BIN_W   = TOTAL_W - THERM_W,
    localparam int UNITS   = (1 << THERM_W) - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               code_valid,
    input  logic [TOTAL_W-1:0] code_in,
    output logic [UNITS-1:0]   therm_en,
    output logic [BIN_W-1:0]   bin_en
);

    logic [TOTAL_W-1:0] held_code;
    logic               xfer_req;
    logic [THERM_W-1:0] upper_field;
    logic [BIN_W-1:0]   lower_field;
    logic [UNITS-1:0]   unary_next;

    seg_hold_stage #(
        .TOTAL_W (TOTAL_W)
    ) u_hold (
        .clk         (clk),
        .rst         (rst),
        .load_i      (code_valid),
        .code_i      (code_in),
        .held_code_o (held_code),
        .xfer_req_o  (xfer_req)
    );

    assign upper_field = held_code[TOTAL_W-1:BIN_W];
    assign lower_field = held_code[BIN_W-1:0];

    seg_therm_decode #(
        .THERM_W (THERM_W)
    ) u_decode (
        .level_i (upper_field),
        .lines_o (unary_next)
    );

    seg_retime_stage #(
        .UNITS (UNITS),
        .BIN_W (BIN_W)
    ) u_retime (
        .clk      (clk),
        .rst      (rst),
        .load_i   (xfer_req),
        .unary_d  (unary_next),
        .binary_d (lower_field),
        .unary_q  (therm_en),
        .binary_q (bin_en)
    );

endmodule

// File: rtl/seg_code_decoder_chk.sv
module seg_code_decoder_chk #(
    parameter int TOTAL_W  = 14,
    parameter int THERM_W  = 6,
    localparam int BIN_W   = TOTAL_W - THERM_W,
    localparam int UNITS   = (1 << THERM_W) - 1
) (
    input logic               clk,
    input logic               rst,
    input logic               code_valid,
    input logic [TOTAL_W-1:0] code_in,
    input logic [UNITS-1:0]   therm_en,
    input logic [BIN_W-1:0]   bin_en
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (therm_en == '0 && bin_en == '0));

    // R3
    therm_contiguous_chk: assert property (@(posedge clk) disable iff (rst)
        ((therm_en + 1'b1) & therm_en) == '0);

    // R2
    therm_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(code_valid, 2))
        |-> (int'($past(code_in, 2) >> BIN_W) == $countones(therm_en)));

    // R4
    bin_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(code_valid, 2))
        |-> (bin_en == BIN_W'($past(code_in, 2))));

    // R5
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(code_valid, 2))
        |-> ($stable(therm_en) && $stable(bin_en)));

endmodule

bind seg_code_decoder seg_code_decoder_chk #(
    .TOTAL_W (TOTAL_W),
    .THERM_W (THERM_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .code_valid (code_valid),
    .code_in    (code_in),
    .therm_en   (therm_en),
    .bin_en     (bin_en)
);

// File: tb/test_seg_code_decoder.sv
module test_seg_code_decoder;

    localparam int  TOTAL_W    = 14;
    localparam int  THERM_W    = 6;
    localparam int  BIN_W      = TOTAL_W - THERM_W;
    localparam int  UNITS      = (1 << THERM_W) - 1;
    localparam int  MAX_CODE   = (1 << TOTAL_W) - 1;
    localparam time CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               code_valid = 1'b0;
    logic [TOTAL_W-1:0] code_in = '0;
    logic [UNITS-1:0]   therm_en;
    logic [BIN_W-1:0]   bin_en;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // Reference model state
    int m_hold = 0;
    int m_out  = 0;
    bit m_pend = 1'b0;

    seg_code_decoder #(
        .TOTAL_W (TOTAL_W),
        .THERM_W (THERM_W)
    ) i_seg_code_decoder (
        .clk        (clk),
        .rst        (rst),
        .code_valid (code_valid),
        .code_in    (code_in),
        .therm_en   (therm_en),
        .bin_en     (bin_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [UNITS-1:0] therm_of(input int code);
        logic [UNITS-1:0] r;
        for (int i = 0; i < UNITS; i++) begin
            r[i] = ((code >> BIN_W) > i);
        end
        return r;
    endfunction

    function automatic logic [BIN_W-1:0] bin_of(input int code);
        return BIN_W'(code % (1 << BIN_W));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_model(input string req);
        check(therm_en == therm_of(m_out), req, "therm_en",
              64'(therm_en), 64'(therm_of(m_out)));
        check(bin_en == bin_of(m_out), req, "bin_en",
              64'(bin_en), 64'(bin_of(m_out)));
    endtask

    // One clock: drive at negedge, advance model at posedge, compare at next negedge
    task automatic tick(input bit v, input int c, input bit r);
        rst        = r;
        code_valid = v;
        code_in    = TOTAL_W'(c);
        @(posedge clk);
        if (r) begin
            m_hold = 0;
            m_pend = 1'b0;
            m_out  = 0;
        end else begin
            if (m_pend) m_out = m_hold;
            m_pend = v;
            if (v) m_hold = c;
        end
        @(negedge clk);
        compare_model("R6");
    endtask

    task automatic load_and_settle(input int c);
        tick(1'b1, c, 1'b0);
        tick(1'b0, 0, 1'b0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick(1'b0, 0, 1'b1);

        // R1 reset state
        check(therm_en == '0 && bin_en == '0, "R1", "reset outputs",
              64'(therm_en) | 64'(bin_en), 64'd0);

        // R9 code zero
        load_and_settle(0);
        check(therm_en == '0 && bin_en == '0, "R9", "code zero",
              64'(therm_en) | 64'(bin_en), 64'd0);

        // R7 double buffering with consecutive strobes
        tick(1'b1, 'h1234, 1'b0);
        check(therm_en == therm_of(0) && bin_en == bin_of(0), "R7",
              "old code during first load", 64'(bin_en), 64'(bin_of(0)));
        tick(1'b1, 'h2ABC, 1'b0);
        check(therm_en == therm_of('h1234) && bin_en == bin_of('h1234), "R7",
              "previous code while new one is held", 64'(bin_en), 64'(bin_of('h1234)));
        tick(1'b0, 0, 1'b0);
        check(therm_en == therm_of('h2ABC) && bin_en == bin_of('h2ABC), "R6",
              "held code after transfer edge", 64'(bin_en), 64'(bin_of('h2ABC)));

        // R5 codes without strobe are ignored
        for (int i = 0; i < 3; i++) begin
            tick(1'b0, MAX_CODE - i, 1'b0);
            check(therm_en == therm_of('h2ABC) && bin_en == bin_of('h2ABC), "R5",
                  "outputs changed without strobe", 64'(bin_en), 64'(bin_of('h2ABC)));
        end

        // R9 full scale
        load_and_settle(MAX_CODE);
        check(therm_en == {UNITS{1'b1}}, "R9", "therm all ones",
              64'(therm_en), 64'({UNITS{1'b1}}));
        check(bin_en == {BIN_W{1'b1}}, "R9", "bin all ones",
              64'(bin_en), 64'({BIN_W{1'b1}}));

        // R8 single-step walk of the unary field
        load_and_settle('h5A);
        for (int k = 0; k < UNITS; k++) begin
            logic [UNITS-1:0] prev;
            prev = therm_en;
            load_and_settle(((k + 1) << BIN_W) | 'h5A);
            check($countones(therm_en & ~prev) == 1, "R8", "new lines on step",
                  64'($countones(therm_en & ~prev)), 64'd1);
            check((prev & ~therm_en) == '0, "R8", "lines dropped on step",
                  64'(prev & ~therm_en), 64'd0);
        end

        // R3 line ordering and R2 count at chosen levels
        for (int j = 0; j < 3; j++) begin
            int m;
            m = (j == 0) ? 1 : (j == 1) ? 31 : 62;
            load_and_settle(m << BIN_W);
            check(therm_en[m-1] == 1'b1 && therm_en[m] == 1'b0, "R3",
                  "boundary line", 64'(therm_en), 64'(therm_of(m << BIN_W)));
            check($countones(therm_en) == m, "R2", "line count",
                  64'($countones(therm_en)), 64'(m));
        end

        // Random traffic: R2, R4, R10 against the model
        for (int i = 0; i < 300; i++) begin
            int c;
            bit v;
            c = int'($urandom_range(MAX_CODE, 0));
            v = ($urandom_range(3, 0) != 0);
            tick(v, c, 1'b0);
            check($countones(therm_en) == (m_out >> BIN_W), "R2", "random count",
                  64'($countones(therm_en)), 64'(m_out >> BIN_W));
            check(bin_en == BIN_W'(m_out), "R4", "random binary field",
                  64'(bin_en), 64'(bin_of(m_out)));
            check($countones(therm_en) * (1 << BIN_W) + int'(bin_en) == m_out, "R10",
                  "total weight", 64'($countones(therm_en) * (1 << BIN_W) + int'(bin_en)),
                  64'(m_out));
        end

        // R1 reset while a transfer is pending
        tick(1'b1, 'h2345, 1'b0);
        tick(1'b0, 0, 1'b1);
        check(therm_en == '0 && bin_en == '0, "R1", "reset over pending transfer",
              64'(therm_en) | 64'(bin_en), 64'd0);
        tick(1'b0, 0, 1'b0);
        check(therm_en == '0 && bin_en == '0, "R1", "held code leaked after reset",
              64'(therm_en) | 64'(bin_en), 64'd0);

        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog timeout actual=running expected=done");
            finish_run();
        end
    end

endmodule